// File: doc/BRIEF.md
# Periodic and On-Demand Conversion Scheduler

This block decides when a temperature-compensated oscillator takes a new temperature reading. A free-running counter of 1 Hz ticks asks for a conversion once every 64 seconds. Software can also ask for a conversion by writing a force bit. When a request is accepted, the scheduler sends a one-cycle start pulse to an external conversion engine. It then waits for that engine's done pulse. After done, it gives a one-cycle strobe that allows the oscillator's load capacitance value to be updated.

A busy output covers the whole cycle from start to the update strobe, so software can poll it before forcing. A force write that arrives while busy is dropped. A periodic request that falls due while busy is kept. It is served right after the running cycle finishes. Forced conversions never move the periodic schedule.

Top module: `conv_sched`

## Requirements
- R1: After reset, busy_o, start_o, load_upd_o and force_o are all 0, and the periodic tick count starts from zero.
- R2: A force write (force_wr_i = 1) seen while idle makes start_o high for exactly one cycle, in the cycle after the write. busy_o rises in the same cycle as start_o.
- R3: busy_o stays high until done_i is seen. load_upd_o is then high for exactly one cycle, the cycle after done_i, and busy_o falls in the cycle after that.
- R4: load_upd_o stays low while the scheduler waits for done_i.
- R5: A force write made while busy is ignored. It causes no start_o pulse, either at once or after the running cycle ends.
- R6: force_o reads 1 from the cycle after an accepted force write until the update strobe has been given, and then reads 0.
- R7: Every 64th tick_1hz_i pulse counted from reset starts a periodic conversion. start_o goes high in the cycle after that tick.
- R8: A forced conversion does not restart or shift the 64-tick count.
- R9: A periodic request that falls due while busy is held. start_o pulses in the cycle right after load_upd_o, and busy_o stays high throughout.
- R10: done_i seen while idle is ignored. It produces no load_upd_o and leaves busy_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_1hz_i | input | 1 | One-cycle pulse once per second |
| force_wr_i | input | 1 | One-cycle write of 1 to the force bit |
| done_i | input | 1 | Conversion engine finished |
| start_o | output | 1 | One-cycle start pulse to the conversion engine |
| busy_o | output | 1 | A conversion/update cycle is underway |
| force_o | output | 1 | Read-back of the force bit |
| load_upd_o | output | 1 | One-cycle strobe allowing a load value update |

## Verification
The hardest case to reach is a periodic request that falls due while a forced cycle is still running. The request must be held, and it must start directly out of the update cycle. The bench gets there by counting ticks from reset. It runs the count to one tick short of a 64-tick boundary and forces a conversion. It sends the boundary tick while the engine is held waiting, and only then returns done. The same tick count shows that the earlier forced cycle did not shift the periodic boundary.

// File: rtl/conv_sched_pkg.sv
package conv_sched_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_UPD  = 2'd2
  } sched_st_e;
endpackage

// File: rtl/conv_period_timer.sv
module conv_period_timer #(
  parameter int unsigned PERIOD_S = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic due_o
);
  localparam int unsigned CntW = (PERIOD_S > 2) ? $clog2(PERIOD_S) : 1;
  localparam logic [CntW-1:0] Last = CntW'(PERIOD_S - 1);

  logic [CntW-1:0] cnt_q;
  logic            wrap;

  assign wrap  = (cnt_q == Last);
  assign due_o = tick_i & wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (tick_i)  cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/conv_sched_fsm.sv
module conv_sched_fsm
  import conv_sched_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic due_i,
  input  logic force_wr_i,
  input  logic done_i,
  output logic start_o,
  output logic busy_o,
  output logic force_o,
  output logic load_upd_o
);
  sched_st_e st_q, st_d;
  logic      pend_q, pend_d;
  logic      start_q, start_d;
  logic      force_q, force_d;

  always_comb begin
    st_d    = st_q;
    start_d = 1'b0;
    force_d = force_q;
    unique case (st_q)
      ST_IDLE: begin
        if (force_wr_i || pend_q || due_i) begin
          st_d    = ST_CONV;
          start_d = 1'b1;
        end
        if (force_wr_i) force_d = 1'b1;
      end
      ST_CONV: if (done_i) st_d = ST_UPD;
      ST_UPD: begin
        force_d = 1'b0;
        // back-to-back periodic run held while busy
        if (pend_q || due_i) begin
          st_d    = ST_CONV;
          start_d = 1'b1;
        end else begin
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    pend_d = start_d ? 1'b0 : (pend_q | due_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      pend_q  <= 1'b0;
      start_q <= 1'b0;
      force_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      pend_q  <= pend_d;
      start_q <= start_d;
      force_q <= force_d;
    end
  end

  assign start_o    = start_q;
  assign busy_o     = (st_q != ST_IDLE);
  assign force_o    = force_q;
  assign load_upd_o = (st_q == ST_UPD);
endmodule

// File: rtl/conv_sched.sv
module conv_sched #(
  parameter int unsigned PERIOD_S = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_1hz_i,
  input  logic force_wr_i,
  input  logic done_i,
  output logic start_o,
  output logic busy_o,
  output logic force_o,
  output logic load_upd_o
);
  logic due;

  conv_period_timer #(.PERIOD_S(PERIOD_S)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_1hz_i),
    .due_o  (due)
  );

  conv_sched_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .due_i      (due),
    .force_wr_i (force_wr_i),
    .done_i     (done_i),
    .start_o    (start_o),
    .busy_o     (busy_o),
    .force_o    (force_o),
    .load_upd_o (load_upd_o)
  );
endmodule

// File: rtl/conv_sched_chk.sv
module conv_sched_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic force_wr_i,
  input logic done_i,
  input logic start_o,
  input logic busy_o,
  input logic force_o,
  input logic load_upd_o
);
  a_r2_start_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  a_r2_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> busy_o);
  a_r3_upd_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(load_upd_o) |-> $past(done_i && busy_o));
  a_r3_upd_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_upd_o |=> !load_upd_o);
  a_r4_no_upd_waiting: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !load_upd_o && !done_i) |=> !load_upd_o);
  a_r6_force_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_o |-> busy_o);
  a_r6_force_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_upd_o |=> !force_o);
  a_r10_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && done_i) |=> !load_upd_o);
endmodule

bind conv_sched conv_sched_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .force_wr_i (force_wr_i),
  .done_i     (done_i),
  .start_o    (start_o),
  .busy_o     (busy_o),
  .force_o    (force_o),
  .load_upd_o (load_upd_o)
);

// File: tb/conv_sched_tb.sv
`timescale 1ns/1ps
module conv_sched_tb;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_1hz_i = 1'b0;
  logic force_wr_i = 1'b0;
  logic done_i = 1'b0;
  logic start_o, busy_o, force_o, load_upd_o;

  int n_chk = 0;
  int n_bad = 0;
  int ticks = 0;
  int starts_seen = 0;
  bit finished = 1'b0;

  always #4 clk_i = ~clk_i;

  conv_sched u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_1hz_i(tick_1hz_i),
    .force_wr_i(force_wr_i), .done_i(done_i), .start_o(start_o),
    .busy_o(busy_o), .force_o(force_o), .load_upd_o(load_upd_o)
  );

  always @(negedge clk_i) if (rst_ni && start_o) starts_seen++;

  task automatic chk(input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b", what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic send_tick();
    tick_1hz_i = 1'b1;
    @(negedge clk_i);
    tick_1hz_i = 1'b0;
    ticks++;
  endtask

  task automatic send_done();
    done_i = 1'b1;
    @(negedge clk_i);
    done_i = 1'b0;
  endtask

  task automatic t_reset();
    chk(busy_o, 1'b0, "R1 busy after reset");
    chk(start_o, 1'b0, "R1 start after reset");
    chk(load_upd_o, 1'b0, "R1 load_upd after reset");
    chk(force_o, 1'b0, "R1 force after reset");
  endtask

  task automatic t_done_idle();
    send_done();
    chk(load_upd_o, 1'b0, "R10 load_upd after idle done");
    chk(busy_o, 1'b0, "R10 busy after idle done");
  endtask

  task automatic t_force();
    int s0;
    force_wr_i = 1'b1;
    @(negedge clk_i);
    force_wr_i = 1'b0;
    chk(start_o, 1'b1, "R2 start after force");
    chk(busy_o, 1'b1, "R2 busy with start");
    chk(force_o, 1'b1, "R6 force readback set");
    cyc(1);
    chk(start_o, 1'b0, "R2 start one cycle");
    cyc(3);
    chk(load_upd_o, 1'b0, "R4 no update while waiting");
    chk(busy_o, 1'b1, "R3 busy while waiting");
    s0 = starts_seen;
    force_wr_i = 1'b1;
    @(negedge clk_i);
    force_wr_i = 1'b0;
    chk(start_o, 1'b0, "R5 no start on busy force");
    chk(force_o, 1'b1, "R6 force still set");
    send_done();
    chk(load_upd_o, 1'b1, "R3 update after done");
    chk(busy_o, 1'b1, "R3 busy during update");
    cyc(1);
    chk(load_upd_o, 1'b0, "R3 update one cycle");
    chk(busy_o, 1'b0, "R3 busy falls");
    chk(force_o, 1'b0, "R6 force cleared");
    cyc(5);
    chk(starts_seen == s0, 1'b1, "R5 busy force dropped");
    chk(busy_o, 1'b0, "R5 stays idle");
  endtask

  task automatic t_periodic();
    while (ticks < 63) begin
      send_tick();
      cyc(1);
    end
    chk(busy_o, 1'b0, "R8 no run before 64th tick");
    send_tick();
    chk(start_o, 1'b1, "R7 start on 64th tick");
    chk(busy_o, 1'b1, "R7 busy on periodic");
    chk(force_o, 1'b0, "R7 periodic run not forced");
    cyc(2);
    send_done();
    chk(load_upd_o, 1'b1, "R7 periodic update");
    cyc(1);
    chk(busy_o, 1'b0, "R7 back to idle");
  endtask

  task automatic t_pending();
    while (ticks < 127) begin
      send_tick();
      cyc(1);
    end
    chk(busy_o, 1'b0, "R8 idle before 128th tick");
    force_wr_i = 1'b1;
    @(negedge clk_i);
    force_wr_i = 1'b0;
    chk(start_o, 1'b1, "R2 forced start");
    cyc(1);
    send_tick();
    chk(start_o, 1'b0, "R9 no start while busy");
    cyc(3);
    chk(load_upd_o, 1'b0, "R4 waiting on held run");
    send_done();
    chk(load_upd_o, 1'b1, "R9 update of forced run");
    cyc(1);
    chk(start_o, 1'b1, "R9 held run starts");
    chk(busy_o, 1'b1, "R9 busy kept");
    chk(force_o, 1'b0, "R6 force cleared before held run");
    cyc(2);
    send_done();
    chk(load_upd_o, 1'b1, "R9 held run update");
    cyc(1);
    chk(busy_o, 1'b0, "R9 idle after held run");
    cyc(4);
    chk(start_o, 1'b0, "R9 no extra start");
  endtask

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);
    t_reset();
    t_done_idle();
    t_force();
    t_periodic();
    t_pending();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk_i);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule